// File: doc/BRIEF.md
# Indirectly addressed interrupt priority bank

This block stores one 8-bit priority number for each of the 64 major interrupt causes of a hart. Software reaches it through an indirect pair: a select value picks one data word in the window 0x30 to 0x3F, and a data port reads or writes that word. The data word is 32 or 64 bits wide, chosen by a parameter. Each word packs consecutive interrupt priorities, one per byte, with the lowest-numbered interrupt in the lowest byte. The interrupt prioritiser reads the whole bank at once through a flat output holding all 64 bytes.

Parameters set how many low priority bits each byte keeps (1 to 8). A mask marks which interrupt enables are writable, and a second mask marks which priority fields may be set. A byte is settable only when both masks allow it. The byte of the machine external interrupt (cause 11) can never be set. Every other byte is fixed at zero. In 64-bit mode only even select values address a word. An odd select value inside the window raises an illegal-access flag and changes nothing. Decoding the select register itself and raising any trap are left to the surrounding CSR logic.

The access port is a plain control interface with no back-pressure. An access strobe qualifies the select, write enable and write data. The read data and the illegal flag are combinational in the same cycle. A write lands at the next rising clock edge.

Top module: `iprio_bank`

## Requirements
- R1: An active-low reset clears every priority byte to zero. The flat output and every word read back zero after reset.
- R2: With 32-bit words, select 0x30+k returns interrupts 4k, 4k+1, 4k+2 and 4k+3 in bits 7:0, 15:8, 23:16 and 31:24.
- R3: With 64-bit words, even select 0x30+2m returns interrupts 8m to 8m+7. Interrupt 8m+j sits in bits 8j+7:8j.
- R4: With 64-bit words, an access whose select is odd and lies in 0x31..0x3F drives the illegal flag high and returns zero read data. A write with such a select changes no byte.
- R5: A settable byte keeps only its low PRIO_BITS bits. Its upper bits read zero, and writes to them are dropped.
- R6: A byte whose enable bit is read-only zero, or whose field is not marked settable, reads zero and ignores writes.
- R7: The byte of interrupt 11 (bits 31:24 of select 0x32 in 32-bit mode) always reads zero.
- R8: A select outside 0x30..0x3F leaves the illegal flag low, returns zero read data and changes no byte.
- R9: A write appears on the flat priority output, in byte lane 8i for interrupt i, from the clock edge that accepts it onward.
- R10: While the access strobe is low, the illegal flag stays low, read data is zero and no byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe qualifying select, write enable and data |
| acc_wr | input | 1 | Write when high, read when low |
| acc_sel | input | 12 | Indirect select value |
| acc_wdata | input | XLEN | Write data word |
| acc_rdata | output | XLEN | Read data word for the selected register |
| acc_illegal | output | 1 | Odd select inside the window in 64-bit mode |
| prio_all | output | 512 | All 64 priority bytes; interrupt i in bits 8i+7:8i |

## Verification
Read data and the illegal flag follow the select in the same cycle. The bench therefore drives each access just after a falling edge and samples these outputs one nanosecond later, before the rising edge. A write becomes visible one rising edge after its access cycle. Each written word is read back in the following access cycle, and the flat output is compared after that edge. Accesses that must be ignored are followed by a read-back of the same or neighbouring word, so that any stray update shows at the ports.

// File: rtl/iprio_bank_pkg.sv
`timescale 1ns/1ps
package iprio_bank_pkg;
  localparam int NUM_IRQ  = 64;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 12;
  localparam int IDX_W    = $clog2(NUM_IRQ);
  localparam int EXT_IRQ  = 11;
  localparam logic [SEL_W-5:0] WINDOW_TAG = 8'h03;

  typedef struct packed {
    logic       hit;
    logic       illegal;
    logic [3:0] reg_idx;
  } sel_dec_t;

  function automatic logic [NUM_IRQ-1:0] settable_set(
      input logic [NUM_IRQ-1:0] ie_wr, input logic [NUM_IRQ-1:0] field_ok);
    logic [NUM_IRQ-1:0] m;
    m = ie_wr & field_ok;
    m[EXT_IRQ] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/iprio_sel_decode.sv
`timescale 1ns/1ps
module iprio_sel_decode
  import iprio_bank_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             acc_en,
  input  logic [SEL_W-1:0] acc_sel,
  output sel_dec_t         dec
);
  localparam bit WIDE = (XLEN == 64);

  logic in_window;
  logic odd_bad;

  always_comb begin
    in_window   = (acc_sel[SEL_W-1:4] == WINDOW_TAG);
    odd_bad     = WIDE && acc_sel[0];
    dec.hit     = acc_en && in_window && !odd_bad;
    dec.illegal = acc_en && in_window && odd_bad;
    dec.reg_idx = acc_sel[3:0];
  end
endmodule

// File: rtl/iprio_field.sv
`timescale 1ns/1ps
module iprio_field
  import iprio_bank_pkg::*;
#(
  parameter int PRIO_BITS = 8,
  parameter bit SETTABLE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] prio
);
  generate
    if (SETTABLE) begin : g_live
      logic [PRIO_BITS-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata[PRIO_BITS-1:0];
      end
      if (PRIO_BITS == BYTE_W) begin : g_full
        assign prio = q;
      end else begin : g_part
        assign prio = {{(BYTE_W-PRIO_BITS){1'b0}}, q};
      end
    end else begin : g_fixed
      logic unused_in;
      assign unused_in = &{1'b0, clk, rst_n, wr_en, wdata};
      assign prio = '0;
    end
  endgenerate
endmodule

// File: rtl/iprio_read_mux.sv
`timescale 1ns/1ps
module iprio_read_mux
  import iprio_bank_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [NUM_IRQ*BYTE_W-1:0] prio_all,
  input  logic [IDX_W-1:0]          base,
  input  logic                      hit,
  output logic [XLEN-1:0]           rdata
);
  localparam int LANES = XLEN / BYTE_W;

  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [IDX_W-1:0] idx;
      assign idx = base + IDX_W'(j);
      assign rdata[j*BYTE_W +: BYTE_W] = hit ? prio_all[idx*BYTE_W +: BYTE_W] : '0;
    end
  endgenerate
endmodule

// File: rtl/iprio_bank.sv
`timescale 1ns/1ps
module iprio_bank
  import iprio_bank_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          PRIO_BITS = 6,
  parameter logic [63:0] IE_WRITABLE = 64'hFFFF_FFFF_FFFF_3EEE,
  parameter logic [63:0] FIELD_OK    = 64'hFFFF_FEFF_FFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [11:0]       acc_sel,
  input  logic [XLEN-1:0]   acc_wdata,
  output logic [XLEN-1:0]   acc_rdata,
  output logic              acc_illegal,
  output logic [511:0]      prio_all
);
  localparam int LANES = XLEN / BYTE_W;
  localparam int LG    = $clog2(LANES);
  localparam logic [NUM_IRQ-1:0] LIVE = settable_set(IE_WRITABLE, FIELD_OK);

  sel_dec_t         dec;
  logic [IDX_W-1:0] base;
  logic             do_write;

  iprio_sel_decode #(.XLEN(XLEN)) u_dec (
    .acc_en (acc_en),
    .acc_sel(acc_sel),
    .dec    (dec)
  );

  assign base        = {dec.reg_idx, 2'b00};
  assign do_write    = dec.hit && acc_wr;
  assign acc_illegal = dec.illegal;

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      localparam int GRP  = i / LANES;
      localparam int LANE = i % LANES;
      logic wr_i;
      assign wr_i = do_write && ((base >> LG) == IDX_W'(GRP));
      iprio_field #(.PRIO_BITS(PRIO_BITS), .SETTABLE(LIVE[i])) u_fld (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_i),
        .wdata(acc_wdata[LANE*BYTE_W +: BYTE_W]),
        .prio (prio_all[i*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

  iprio_read_mux #(.XLEN(XLEN)) u_rd (
    .prio_all(prio_all),
    .base    (base),
    .hit     (dec.hit),
    .rdata   (acc_rdata)
  );
endmodule

// File: rtl/iprio_bank_chk.sv
`timescale 1ns/1ps
module iprio_bank_chk #(
  parameter int XLEN      = 32,
  parameter int PRIO_BITS = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_en,
  input logic [11:0]     acc_sel,
  input logic [XLEN-1:0] acc_rdata,
  input logic            acc_illegal,
  input logic [511:0]    prio_all
);
  function automatic logic [511:0] high_bits();
    logic [511:0] m;
    m = '0;
    for (int i = 0; i < 64; i++)
      for (int b = PRIO_BITS; b < 8; b++) m[i*8+b] = 1'b1;
    return m;
  endfunction
  localparam logic [511:0] HIGH = high_bits();

  logic outside;
  assign outside = (acc_sel[11:4] != 8'h03);

  p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> prio_all == '0);
  p_illegal_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |=> $stable(prio_all));
  p_illegal_zero_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |-> acc_rdata == '0);
  p_high_bits_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_all & HIGH) == '0);
  p_ext_byte_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prio_all[95:88] == 8'h00);
  p_outside_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && outside) |=> $stable(prio_all));
  p_outside_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (!acc_illegal && acc_rdata == '0));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(prio_all));
  p_idle_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> !acc_illegal);
endmodule

bind iprio_bank iprio_bank_chk #(.XLEN(XLEN), .PRIO_BITS(PRIO_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_sel    (acc_sel),
  .acc_rdata  (acc_rdata),
  .acc_illegal(acc_illegal),
  .prio_all   (prio_all)
);

// File: tb/test_iprio_bank.sv
`timescale 1ns/1ps
module test_iprio_bank;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n;

  logic a_en, a_wr, a_ill;
  logic [11:0] a_sel;
  logic [31:0] a_wd, a_rd;
  logic [511:0] a_prio;
  logic b_en, b_wr, b_ill;
  logic [11:0] b_sel;
  logic [63:0] b_wd, b_rd;
  logic [511:0] b_prio;

  int checks = 0;
  int errors = 0;

  iprio_bank i_iprio_bank (
    .clk(clk), .rst_n(rst_n), .acc_en(a_en), .acc_wr(a_wr), .acc_sel(a_sel),
    .acc_wdata(a_wd), .acc_rdata(a_rd), .acc_illegal(a_ill), .prio_all(a_prio));

  iprio_bank #(.XLEN(64), .PRIO_BITS(8)) i_iprio_bank_w64 (
    .clk(clk), .rst_n(rst_n), .acc_en(b_en), .acc_wr(b_wr), .acc_sel(b_sel),
    .acc_wdata(b_wd), .acc_rdata(b_rd), .acc_illegal(b_ill), .prio_all(b_prio));

  typedef struct packed {
    logic [11:0] sel;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{12'h030, 32'hFFFF_FFFF, 32'h3F3F_3F00},
    '{12'h032, 32'h1234_5678, 32'h0034_1600},
    '{12'h033, 32'hC1C2_C3C4, 32'h0000_0304},
    '{12'h03A, 32'h0A0B_0C0D, 32'h0A0B_0C00},
    '{12'h03F, 32'h8040_2001, 32'h0000_2001},
    '{12'h031, 32'h1122_3344, 32'h1122_3300}
  };

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drv_a(input logic en, input logic wr, input logic [11:0] sel, input logic [31:0] wd);
    @(negedge clk);
    a_en = en; a_wr = wr; a_sel = sel; a_wd = wd;
    b_en = 1'b0; b_wr = 1'b0;
    #1;
  endtask

  task automatic drv_b(input logic en, input logic wr, input logic [11:0] sel, input logic [63:0] wd);
    @(negedge clk);
    b_en = en; b_wr = wr; b_sel = sel; b_wd = wd;
    a_en = 1'b0; a_wr = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] snap;
    rst_n = 1'b0;
    a_en = 0; a_wr = 0; a_sel = '0; a_wd = '0;
    b_en = 0; b_wr = 0; b_sel = '0; b_wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 flat A", a_prio, '0);
    chk("R1 flat B", b_prio, '0);
    for (int k = 0; k < 16; k++) begin
      drv_a(1, 0, 12'h030 + 12'(k), '0);
      chk("R1 word A", 512'(a_rd), '0);
    end

    // R2/R5/R6/R7: table walk, write then read back
    for (int v = 0; v < 6; v++) begin
      drv_a(1, 1, VEC[v].sel, VEC[v].wd);
      chk("R2 write no illegal", 512'(a_ill), '0);
      drv_a(1, 0, VEC[v].sel, '0);
      chk("R2 R5 R6 R7 readback", 512'(a_rd), 512'(VEC[v].exp));
    end

    // R9: flat output lanes
    chk("R9 irq9 lane", 512'(a_prio[9*8 +: 8]), 512'(8'h16));
    chk("R9 irq13 lane", 512'(a_prio[13*8 +: 8]), 512'(8'h03));
    chk("R7 irq11 lane", 512'(a_prio[11*8 +: 8]), '0);
    chk("R6 irq40 lane", 512'(a_prio[40*8 +: 8]), '0);

    // R8: selects outside the window
    snap = a_prio;
    drv_a(1, 1, 12'h040, 32'hFFFF_FFFF);
    chk("R8 above flag", 512'(a_ill), '0);
    chk("R8 above rdata", 512'(a_rd), '0);
    drv_a(1, 1, 12'h02F, 32'hFFFF_FFFF);
    chk("R8 below flag", 512'(a_ill), '0);
    drv_a(1, 1, 12'h130, 32'hFFFF_FFFF);
    drv_a(1, 0, 12'h030, '0);
    chk("R8 word unchanged", 512'(a_rd), 512'(32'h3F3F_3F00));
    chk("R8 flat unchanged", a_prio, snap);

    // R5/R7: all-ones write to the word holding interrupt 11
    drv_a(1, 1, 12'h032, 32'hFFFF_FFFF);
    drv_a(1, 0, 12'h032, '0);
    chk("R5 R7 all ones", 512'(a_rd), 512'(32'h003F_3F00));

    // R10: strobe low
    snap = a_prio;
    drv_a(0, 1, 12'h030, 32'h0);
    chk("R10 idle rdata", 512'(a_rd), '0);
    chk("R10 idle flag", 512'(a_ill), '0);
    drv_a(1, 0, 12'h030, '0);
    chk("R10 idle no write", 512'(a_rd), 512'(32'h3F3F_3F00));
    chk("R10 flat", a_prio, snap);

    // R3: 64-bit packing
    drv_b(1, 1, 12'h030, 64'h0807_0605_0403_0201);
    drv_b(1, 0, 12'h030, '0);
    chk("R3 word0", 512'(b_rd), 512'(64'h0807_0600_0403_0200));
    chk("R3 irq7 lane", 512'(b_prio[7*8 +: 8]), 512'(8'h08));

    // R4: odd select in 64-bit mode
    snap = b_prio;
    drv_b(1, 1, 12'h031, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R4 flag", 512'(b_ill), 512'(1'b1));
    chk("R4 rdata", 512'(b_rd), '0);
    drv_b(1, 0, 12'h032, '0);
    chk("R4 neighbour untouched", 512'(b_rd), '0);
    chk("R4 flat", b_prio, snap);
    drv_b(1, 0, 12'h03F, '0);
    chk("R4 top odd flag", 512'(b_ill), 512'(1'b1));

    // R3/R5/R6/R7 in 64-bit mode with 8 kept bits
    drv_b(1, 1, 12'h032, 64'hFFFF_FFFF_FFFF_FFFF);
    drv_b(1, 0, 12'h032, '0);
    chk("R3 R6 R7 word2", 512'(b_rd), 512'(64'h0000_FFFF_00FF_FF00));
    drv_b(1, 0, 12'h03E, '0);
    chk("R3 word7 untouched", 512'(b_rd), '0);

    // R10/R8 in 64-bit mode
    drv_b(0, 0, 12'h031, '0);
    chk("R10 odd idle flag", 512'(b_ill), '0);
    drv_b(1, 0, 12'h041, '0);
    chk("R8 odd outside flag", 512'(b_ill), '0);

    // R1: reset after writes
    @(negedge clk);
    a_en = 0; b_en = 0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset A", a_prio, '0);
    chk("R1 re-reset B", b_prio, '0);
    rst_n = 1'b1;
    drv_a(1, 0, 12'h031, '0);
    chk("R1 word after reset", 512'(a_rd), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule